// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog timer with two phases that software drives through five 32-bit word registers. Software loads a first-phase (soft) tick count, arms the timer and sets it running. When the soft count runs out, the block raises a level interrupt and reloads itself from a hard tick count taken from the `hard_ticks` input. If software does not service it before that second count runs out, the block pulses a reset request for one clock and returns to the stopped state.

Software services the timer with four register accesses in a fixed order. It reads the clear register, writes 2 to the control register, writes the soft count to the load register, and writes 3 to the control register. After this the block counts in the soft phase again. Both thresholds are in clock ticks, so the block does no conversion from seconds. If the timer is set running without being armed, a count that runs out is treated as spurious: it stops the count, and it raises no interrupt and no reset.

Register offsets, as byte addresses: 0x00 holds the load value, 0x04 the live counter, 0x08 control, 0x0C interrupt clear and 0x10 interrupt status. The two control bits are bit 0, run, and bit 1, armed. The value 3 arms the timer and runs it, 2 pauses it while it stays armed, 1 runs it unarmed, and 0 stops it.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the load, counter and control registers all read 0. Status reads 1 and `irq` and `rst_req` are low.
- R2: A write to offset 0x00 stores the whole 32-bit word, which reads back unchanged. The same edge copies it into the counter (offset 0x04) and selects the soft phase.
- R3: While control bit 0 is 1 the counter drops by one per clock until it reaches 0. While bit 0 is 0 it holds. Control reads back its two bits, with all upper bits 0.
- R4: Expiry means the counter is at 0 while running. Expiry in the soft phase with bit 1 set sets `irq` and loads `hard_ticks` into the counter on the same edge, and counting goes on.
- R5: `irq` stays high until a read of offset 0x0C, which returns 0 and clears it on that edge. Offset 0x10 reads 0 while `irq` is pending and 1 otherwise.
- R6: Expiry in the hard phase pulses `rst_req` high for exactly one clock. On the same edge control and the counter become 0.
- R7: The service sequence (read 0x0C, write 2 to 0x08, write the soft count to 0x00, write 3 to 0x08) performed during the hard phase prevents the reset. The next expiry is a soft one and raises `irq` again.
- R8: Expiry with control equal to 1 (run, not armed) is spurious. It clears bit 0 of control, leaves the counter at 0, and raises neither `irq` nor `rst_req`.
- R9: With control written to 0, the counter holds its value and no expiry occurs, however long the block waits.
- R10: If a read of 0x0C falls in the same cycle as a soft expiry, the new interrupt wins and `irq` is high after that edge.
- R11: A write to 0x00 or 0x08 in a cycle where the block would expire cancels that expiry. Expiry is evaluated again on the next clock.
- R12: Writes to 0x04, 0x0C and 0x10 change nothing. A read of any unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| hard_ticks | input | 32 | Tick count loaded for the hard phase |
| irq | output | 1 | Level interrupt, set on soft expiry |
| rst_req | output | 1 | One-clock system reset request |

## Verification
A read of the clear register can fall in the same cycle as a soft expiry. The bench provokes this by issuing the clear read exactly in the cycle where the counter sits at 0. It then judges that `irq` is still high afterwards. A service write can also fall in the same cycle as an expiry. The bench provokes this by writing control in the cycle where the counter is at 0. It expects that neither the interrupt nor the hard-threshold reload appears on that edge, and that both appear one clock later.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] hard_ticks,
  output logic          irq,
  output logic          rst_req
);

  localparam logic [AW-1:0] OFS_LOAD = AW'(5'h00);
  localparam logic [AW-1:0] OFS_CUR  = AW'(5'h04);
  localparam logic [AW-1:0] OFS_CTRL = AW'(5'h08);
  localparam logic [AW-1:0] OFS_CLR  = AW'(5'h0C);
  localparam logic [AW-1:0] OFS_STAT = AW'(5'h10);

  logic [DW-1:0] load_q, cnt_q;
  logic [1:0]    ctrl_q;
  logic          hard_ph, irq_q, rst_q;

  wire wr      = bus_en & bus_we;
  wire rd      = bus_en & ~bus_we;
  wire wr_load = wr & (bus_addr == OFS_LOAD);
  wire wr_ctrl = wr & (bus_addr == OFS_CTRL);
  wire rd_clr  = rd & (bus_addr == OFS_CLR);

  wire run      = ctrl_q[0];
  wire armed    = ctrl_q[1];
  wire expire   = run & (cnt_q == '0) & ~wr_load & ~wr_ctrl;
  wire soft_exp = expire & armed & ~hard_ph;
  wire hard_exp = expire & armed & hard_ph;
  wire spur_exp = expire & ~armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      hard_ph <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= hard_exp;

      if (wr_load) load_q <= bus_wdata;

      if (wr_load) begin
        cnt_q   <= bus_wdata;
        hard_ph <= 1'b0;
      end else if (soft_exp) begin
        cnt_q   <= hard_ticks;
        hard_ph <= 1'b1;
      end else if (hard_exp) begin
        cnt_q   <= '0;
        hard_ph <= 1'b0;
      end else if (run && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end

      if (wr_ctrl)       ctrl_q    <= bus_wdata[1:0];
      else if (hard_exp) ctrl_q    <= 2'b00;
      else if (spur_exp) ctrl_q[0] <= 1'b0;

      if (soft_exp)    irq_q <= 1'b1;
      else if (rd_clr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        OFS_LOAD: bus_rdata = load_q;
        OFS_CUR:  bus_rdata = cnt_q;
        OFS_CTRL: bus_rdata = {{(DW-2){1'b0}}, ctrl_q};
        OFS_STAT: bus_rdata = irq_q ? '0 : DW'(1);
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign irq     = irq_q;
  assign rst_req = rst_q;

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] hard_ticks,
  input logic          irq,
  input logic          rst_req,
  input logic [DW-1:0] cnt_q,
  input logic [1:0]    ctrl_q
);

  a_r6_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r6_rst_stops: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt_q == '0 && ctrl_q == 2'b00));

  a_r6_rst_needs_armed_run: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(ctrl_q) == 2'b11);

  a_r4_hard_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cnt_q == $past(hard_ticks));

  a_r5_status_tracks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == AW'(5'h10)) |-> ((bus_rdata == '0) == irq));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !(bus_en && bus_we)) |=> $stable(cnt_q));

  a_r8_spurious_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 2'b01 && cnt_q == '0 && !(bus_en && bus_we)) |=> (ctrl_q == 2'b00 && !rst_req && !$rose(irq)));

endmodule

bind wdt_two_stage wdt_two_stage_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .hard_ticks(hard_ticks),
  .irq(irq), .rst_req(rst_req), .cnt_q(cnt_q), .ctrl_q(ctrl_q)
);

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_LOAD = 5'h00, A_CUR = 5'h04, A_CTRL = 5'h08,
                         A_CLR = 5'h0C, A_STAT = 5'h10;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] hard_ticks = 32'd4;
  logic irq, rst_req;

  wdt_two_stage dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hard_ticks(hard_ticks), .irq(irq), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0, n_chk = 0, n_err = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int kind, logic [31:0] e, string tag);
    item_t it;
    it.due = cyc; it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {31'b0, irq};
        default: act = {31'b0, rst_req};
      endcase
      n_chk++;
      if (it.due != cyc || act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%h expected=%h (cycle %0d)", it.tag, act, it.exp, cyc);
      end
    end
  end

  task automatic op_idle();
    @(posedge clk); #1; bus_en = 0; bus_we = 0;
  endtask
  task automatic op_wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1; bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask
  task automatic op_rd(logic [4:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1; bus_en = 1; bus_we = 0; bus_addr = a;
    push(0, e, tag);
  endtask
  task automatic exp_irq(logic v, string tag); push(1, {31'b0, v}, tag); endtask
  task automatic exp_rst(logic v, string tag); push(2, {31'b0, v}, tag); endtask
  task automatic idles(int n);
    for (int i = 0; i < n; i++) op_idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    op_rd(A_LOAD, 0, "R1 load"); exp_irq(0, "R1 irq"); exp_rst(0, "R1 rst");
    op_rd(A_CUR, 0, "R1 cur");
    op_rd(A_CTRL, 0, "R1 ctrl");
    op_rd(A_STAT, 1, "R1 status");

    // R2 full-width readback, copied into counter
    op_wr(A_LOAD, 32'hDEAD_BEEF);
    op_rd(A_LOAD, 32'hDEAD_BEEF, "R2 load readback");
    op_rd(A_CUR, 32'hDEAD_BEEF, "R2 counter copy");

    // R3 decrement, readback, pause hold
    op_wr(A_CTRL, 2);
    op_wr(A_LOAD, 10);
    op_wr(A_CTRL, 3);
    op_rd(A_CUR, 10, "R3 first");
    op_rd(A_CUR, 9, "R3 dec");
    op_rd(A_CUR, 8, "R3 dec");
    op_rd(A_CTRL, 3, "R3 ctrl readback");
    op_wr(A_CTRL, 2);
    op_rd(A_CUR, 5, "R3 pause");
    op_rd(A_CUR, 5, "R3 hold");

    // R4/R5/R6 soft expiry, hard expiry
    op_wr(A_CTRL, 3);
    idles(5);
    op_rd(A_CUR, 0, "R4 at zero"); exp_irq(0, "R4 before expiry");
    op_rd(A_CUR, 4, "R4 hard reload"); exp_irq(1, "R4 irq");
    op_rd(A_STAT, 0, "R5 status pending");
    op_rd(A_CUR, 2, "R4 hard counting");
    op_idle();
    op_rd(A_CUR, 0, "R6 hard zero"); exp_rst(0, "R6 no early rst");
    op_rd(A_CTRL, 0, "R6 ctrl cleared"); exp_rst(1, "R6 rst pulse");
    op_rd(A_CUR, 0, "R6 counter cleared"); exp_rst(0, "R6 one cycle"); exp_irq(1, "R5 level");
    op_rd(A_CLR, 0, "R5 clear read");
    op_rd(A_STAT, 1, "R5 status idle"); exp_irq(0, "R5 cleared");

    // R7 service during hard phase
    op_wr(A_LOAD, 3);
    op_wr(A_CTRL, 3);
    idles(4);
    op_rd(A_CLR, 0, "R7 clear"); exp_irq(1, "R7 soft expiry");
    op_wr(A_CTRL, 2);
    op_wr(A_LOAD, 3);
    op_wr(A_CTRL, 3);
    op_rd(A_CUR, 3, "R7 soft restart"); exp_irq(0, "R7 irq cleared");
    op_rd(A_CUR, 2, "R7 counting"); exp_rst(0, "R7 no reset");
    op_idle(); exp_rst(0, "R7 no reset late");
    op_idle();
    op_rd(A_CUR, 4, "R7 soft again"); exp_irq(1, "R7 irq again");

    // R9 stop holds
    op_wr(A_CTRL, 0);
    op_rd(A_CUR, 2, "R9 stopped");
    idles(8);
    op_rd(A_CUR, 2, "R9 still held"); exp_rst(0, "R9 no reset");
    op_rd(A_CLR, 0, "R9 clear");
    op_idle(); exp_irq(0, "R9 irq clear");

    // R10 clear collides with soft expiry
    op_wr(A_LOAD, 2);
    op_wr(A_CTRL, 3);
    idles(2);
    op_rd(A_CLR, 0, "R10 clear at expiry"); exp_irq(0, "R10 before");
    op_wr(A_CTRL, 0); exp_irq(1, "R10 set wins");
    op_rd(A_CLR, 0, "R10 clear");
    op_idle(); exp_irq(0, "R10 cleared");

    // R11 write cancels expiry
    op_wr(A_LOAD, 2);
    op_wr(A_CTRL, 3);
    idles(2);
    op_wr(A_CTRL, 3); exp_irq(0, "R11 before");
    op_rd(A_CUR, 0, "R11 no reload"); exp_irq(0, "R11 cancelled");
    op_rd(A_CUR, 4, "R11 late reload"); exp_irq(1, "R11 late irq");
    op_wr(A_CTRL, 0);
    op_rd(A_CLR, 0, "R11 clear");
    op_idle(); exp_irq(0, "R11 cleared");

    // R8 spurious expiry
    op_wr(A_LOAD, 2);
    op_wr(A_CTRL, 1);
    idles(3);
    op_rd(A_CTRL, 0, "R8 run cleared"); exp_irq(0, "R8 no irq"); exp_rst(0, "R8 no rst");
    op_rd(A_CUR, 0, "R8 no reload"); exp_irq(0, "R8 no irq"); exp_rst(0, "R8 no rst");
    op_rd(A_STAT, 1, "R8 status idle");

    // R12 ignored writes, unmapped read
    op_wr(A_LOAD, 7);
    op_wr(A_CUR, 99);
    op_wr(A_CLR, 1);
    op_wr(A_STAT, 0);
    op_rd(A_CUR, 7, "R12 counter untouched");
    op_rd(A_LOAD, 7, "R12 load untouched");
    op_rd(5'h14, 0, "R12 unmapped");
    op_rd(A_STAT, 1, "R12 status untouched"); exp_irq(0, "R12 irq untouched");

    idles(2);
    if (sb.size() != 0) begin
      n_err++;
      $display("FAIL R12 scoreboard: actual=%0d expected=0 pending", sb.size());
    end
    done = 1;
    finish_run();
  end
endmodule